// File: doc/BRIEF.md
# RGB Sum Window-Threshold Masker

This block classifies a stream of colour pixels. Each pixel's red, green and blue components are added into one pseudo-chromatic value, and a one-bit mask is raised when that value falls inside a programmable window whose two edges both count as inside. The mask leaves the block with its own valid strobe, the pixel's row and column inside the frame, and an end-of-frame marker. All of these appear on the same clock edge.

Frames are walked column by column. The row index changes fastest, and the column index advances when a column's last row has been classified. A build-time parameter picks the input side. With parallel input, all three channels arrive together in one beat. With serialized input, one shared channel bus carries red, green and blue on successive accepted beats. The core behind the input side is the same in both cases. The thresholds and the frame dimensions are runtime values that are loaded together through a small configuration port.

Top module: `rgb_window_masker`

## Requirements
- R1: The tested value is the unsigned sum of the three 10-bit channels, held in 12 bits with no wrap; the largest possible sum is 3069.
- R2: out_mask is 1 exactly when cfg low ≤ sum ≤ cfg high, both inclusive; when low exceeds high every mask is 0.
- R3: After reset the window is low = 2, high = 1022 and the frame is 4 rows by 3 columns. A cycle with cfg_we high loads low, high, row count and column count, and it returns the scan position to row 0, column 0.
- R4: Results are numbered column-major. Within a column out_row counts 0 to rows-1. After the last row, out_row returns to 0 and out_col increments. After the last column, out_col returns to 0.
- R5: out_valid is high for exactly one cycle per completed pixel. If the edge that accepts a pixel's last channel is edge n, then out_valid and all output fields are updated by edge n+2. No other cycle carries out_valid.
- R6: In serialized mode, channel beats come on px_r in the order R, G, B. The pixel completes on the third accepted beat, and cycles with px_valid low are ignored.
- R7: In serialized mode, a beat with px_sop high is always taken as a new R beat. Any partly gathered pixel is discarded and produces no output.
- R8: out_eof is high, together with out_valid, only for the result at row rows-1 of column cols-1.
- R9: In parallel mode, every cycle with px_valid high is one pixel taken from px_r, px_g and px_b, and px_sop has no effect.
- R10: A synchronous reset (rst_n low at an edge) clears the scan position and every pixel in flight. No out_valid follows from pixels accepted before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Load window and frame size, restart scan |
| cfg_lo | input | 12 | Window low edge (inclusive) |
| cfg_hi | input | 12 | Window high edge (inclusive) |
| cfg_rows | input | 8 | Rows per column |
| cfg_cols | input | 8 | Columns per frame |
| px_valid | input | 1 | Input beat qualifier |
| px_sop | input | 1 | Serialized mode: beat is the R channel |
| px_r | input | 10 | Red channel; the shared channel bus in serialized mode |
| px_g | input | 10 | Green channel (parallel mode) |
| px_b | input | 10 | Blue channel (parallel mode) |
| out_valid | output | 1 | Result strobe |
| out_mask | output | 1 | Window hit |
| out_row | output | 8 | Row of the result |
| out_col | output | 8 | Column of the result |
| out_eof | output | 1 | Result is the last pixel of the frame |

## Verification
The hardest conditions to reach are sums that fall exactly on a window edge, or one step outside it, because uniformly random channels almost never produce them. The stimulus picks a target sum from low-1, low, high and high+1 and splits that target across the three channels. Two other conditions need precise timing: a resynchronising start flag that arrives after a partial serialized pixel, and a reset that lands while a pixel is between pipeline stages. Both are driven as directed sequences. Random frame sizes, including single-row frames, then carry the scan through many column and frame wraps.

// File: rtl/rgbm_pkg.sv
package rgbm_pkg;
  typedef enum logic [1:0] {PH_R, PH_G, PH_B} phase_e;

  // Sum of three channels, computed in a width wide enough for any channel size used here.
  function automatic logic [15:0] chan_sum(input logic [15:0] a, input logic [15:0] b,
                                           input logic [15:0] c);
    return a + b + c;
  endfunction

  // Inclusive window test.
  function automatic logic in_window(input logic [15:0] v, input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/rgbm_collect.sv
module rgbm_collect #(
  parameter int CH_W      = 10,
  parameter bit SERIAL_IN = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            px_valid,
  input  logic            px_sop,
  input  logic [CH_W-1:0] px_r,
  input  logic [CH_W-1:0] px_g,
  input  logic [CH_W-1:0] px_b,
  output logic            pix_v,
  output logic [CH_W-1:0] pix_r,
  output logic [CH_W-1:0] pix_g,
  output logic [CH_W-1:0] pix_b
);
  import rgbm_pkg::*;

  generate
    if (SERIAL_IN) begin : g_serial
      phase_e          phase;
      logic [CH_W-1:0] r_hold, g_hold;
      logic            unused_ser;
      assign unused_ser = ^{px_g, px_b};

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          phase  <= PH_R;
          pix_v  <= 1'b0;
          r_hold <= '0;
          g_hold <= '0;
          pix_r  <= '0;
          pix_g  <= '0;
          pix_b  <= '0;
        end else begin
          pix_v <= 1'b0;
          if (px_valid) begin
            if (px_sop || phase == PH_R) begin
              r_hold <= px_r;
              phase  <= PH_G;
            end else if (phase == PH_G) begin
              g_hold <= px_r;
              phase  <= PH_B;
            end else begin
              pix_r <= r_hold;
              pix_g <= g_hold;
              pix_b <= px_r;
              pix_v <= 1'b1;
              phase <= PH_R;
            end
          end
        end
      end

      // A pixel completes only on an accepted beat that carries no start flag.
      AST_SER_THIRD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_v |-> ($past(px_valid) && !$past(px_sop))); // R6
    end else begin : g_parallel
      logic unused_par;
      assign unused_par = px_sop;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pix_v <= 1'b0;
          pix_r <= '0;
          pix_g <= '0;
          pix_b <= '0;
        end else begin
          pix_v <= px_valid;
          if (px_valid) begin
            pix_r <= px_r;
            pix_g <= px_g;
            pix_b <= px_b;
          end
        end
      end

      AST_PAR_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_v |-> $past(px_valid)); // R9
    end
  endgenerate
endmodule

// File: rtl/rgbm_scan.sv
module rgbm_scan #(
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [DIM_W-1:0] rows,
  input  logic [DIM_W-1:0] cols,
  output logic [DIM_W-1:0] cur_row,
  output logic [DIM_W-1:0] cur_col,
  output logic             cur_last
);
  logic last_row, last_col;
  assign last_row = (cur_row == rows - DIM_W'(1));
  assign last_col = (cur_col == cols - DIM_W'(1));
  assign cur_last = last_row && last_col;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cur_row <= '0;
      cur_col <= '0;
    end else if (step) begin
      if (last_row) begin
        cur_row <= '0;
        cur_col <= last_col ? '0 : cur_col + DIM_W'(1);
      end else begin
        cur_row <= cur_row + DIM_W'(1);
      end
    end
  end

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rows != '0) |-> (cur_row < rows)); // R4
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !last_row) |=> ((cur_row == $past(cur_row) + DIM_W'(1)) && $stable(cur_col))); // R4
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && last_row && !last_col) |=> ((cur_row == '0) && (cur_col == $past(cur_col) + DIM_W'(1)))); // R4
endmodule

// File: rtl/rgb_window_masker.sv
module rgb_window_masker #(
  parameter int CH_W      = 10,
  parameter int DIM_W     = 8,
  parameter bit SERIAL_IN = 1'b0,
  parameter int DEF_LO    = 2,
  parameter int DEF_HI    = 1022,
  parameter int DEF_ROWS  = 4,
  parameter int DEF_COLS  = 3,
  localparam int SUM_W    = CH_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SUM_W-1:0] cfg_lo,
  input  logic [SUM_W-1:0] cfg_hi,
  input  logic [DIM_W-1:0] cfg_rows,
  input  logic [DIM_W-1:0] cfg_cols,
  input  logic             px_valid,
  input  logic             px_sop,
  input  logic [CH_W-1:0]  px_r,
  input  logic [CH_W-1:0]  px_g,
  input  logic [CH_W-1:0]  px_b,
  output logic             out_valid,
  output logic             out_mask,
  output logic [DIM_W-1:0] out_row,
  output logic [DIM_W-1:0] out_col,
  output logic             out_eof
);
  import rgbm_pkg::*;

  logic [SUM_W-1:0] thr_lo, thr_hi;
  logic [DIM_W-1:0] rows, cols;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_lo <= SUM_W'(DEF_LO);
      thr_hi <= SUM_W'(DEF_HI);
      rows   <= DIM_W'(DEF_ROWS);
      cols   <= DIM_W'(DEF_COLS);
    end else if (cfg_we) begin
      thr_lo <= cfg_lo;
      thr_hi <= cfg_hi;
      rows   <= cfg_rows;
      cols   <= cfg_cols;
    end
  end

  // Named internal events: completed pixel and its scan position.
  logic            pix_v;
  logic [CH_W-1:0] pix_r, pix_g, pix_b;
  logic [DIM_W-1:0] cur_row, cur_col;
  logic            cur_last;

  rgbm_collect #(.CH_W(CH_W), .SERIAL_IN(SERIAL_IN)) u_collect (
    .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_sop(px_sop),
    .px_r(px_r), .px_g(px_g), .px_b(px_b),
    .pix_v(pix_v), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
  );

  rgbm_scan #(.DIM_W(DIM_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .step(pix_v),
    .rows(rows), .cols(cols),
    .cur_row(cur_row), .cur_col(cur_col), .cur_last(cur_last)
  );

  // Stage 1: channel sum, position travelling alongside.
  logic             s1_v, s1_eof;
  logic [SUM_W-1:0] s1_sum;
  logic [DIM_W-1:0] s1_row, s1_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_sum <= '0;
      s1_row <= '0;
      s1_col <= '0;
      s1_eof <= 1'b0;
    end else begin
      s1_v   <= pix_v;
      s1_sum <= SUM_W'(chan_sum(16'(pix_r), 16'(pix_g), 16'(pix_b)));
      s1_row <= cur_row;
      s1_col <= cur_col;
      s1_eof <= pix_v && cur_last;
    end
  end

  // Stage 2: window compare, every output field registered on one edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= 1'b0;
      out_row   <= '0;
      out_col   <= '0;
      out_eof   <= 1'b0;
    end else begin
      out_valid <= s1_v;
      out_mask  <= s1_v && in_window(16'(s1_sum), 16'(thr_lo), 16'(thr_hi));
      out_row   <= s1_row;
      out_col   <= s1_col;
      out_eof   <= s1_v && s1_eof;
    end
  end

  AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_v, 2)); // R5
  AST_MASK_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mask) |-> ($past(thr_lo) <= $past(thr_hi))); // R2
  AST_EOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid); // R8
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!out_valid && !s1_v)); // R10
endmodule

// File: tb/rgb_window_masker_bench.sv
module rgb_window_masker_bench;
  localparam int CH_W = 10;
  localparam int DIM_W = 8;
  localparam int SUM_W = CH_W + 2;

  typedef struct {
    int due;
    bit mask;
    int row;
    int col;
    bit eof;
  } exp_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [SUM_W-1:0] cfg_lo = '0, cfg_hi = '0;
  logic [DIM_W-1:0] cfg_rows = '0, cfg_cols = '0;

  logic p_valid = 1'b0, p_sop = 1'b0;
  logic [CH_W-1:0] p_r = '0, p_g = '0, p_b = '0;
  logic s_valid = 1'b0, s_sop = 1'b0;
  logic [CH_W-1:0] s_data = '0;

  logic p_ov, p_om, p_oe, s_ov, s_om, s_oe;
  logic [DIM_W-1:0] p_orow, p_ocol, s_orow, s_ocol;

  rgb_window_masker #(.SERIAL_IN(1'b0)) u_rgb_window_masker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
    .px_valid(p_valid), .px_sop(p_sop), .px_r(p_r), .px_g(p_g), .px_b(p_b),
    .out_valid(p_ov), .out_mask(p_om), .out_row(p_orow), .out_col(p_ocol), .out_eof(p_oe)
  );

  rgb_window_masker #(.SERIAL_IN(1'b1)) u_rgb_window_masker_ser (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
    .px_valid(s_valid), .px_sop(s_sop), .px_r(s_data), .px_g('0), .px_b('0),
    .out_valid(s_ov), .out_mask(s_om), .out_row(s_orow), .out_col(s_ocol), .out_eof(s_oe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  exp_t qp[$], qs[$];
  int m_lo = 2, m_hi = 1022, m_rows = 4, m_cols = 3;
  int mrow[2], mcol[2];

  function automatic bit ref_mask(int r, int g, int b, int lo, int hi);
    int s = r + g + b;
    return (s >= lo) && (s <= hi);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic push_exp(int k, int r, int g, int b);
    exp_t e;
    e.due  = cyc + 3;
    e.mask = ref_mask(r, g, b, m_lo, m_hi);
    e.row  = mrow[k];
    e.col  = mcol[k];
    e.eof  = (mrow[k] == m_rows - 1) && (mcol[k] == m_cols - 1);
    if (mrow[k] == m_rows - 1) begin
      mrow[k] = 0;
      mcol[k] = (mcol[k] == m_cols - 1) ? 0 : mcol[k] + 1;
    end else mrow[k] = mrow[k] + 1;
    if (k == 0) qp.push_back(e); else qs.push_back(e);
  endtask

  task automatic compare(string tag, exp_t e, bit m, int row, int col, bit eof);
    chk(m == e.mask, "R1/R2", {tag, " mask"}, m, e.mask);
    chk(row == e.row && col == e.col, "R4", {tag, " row*256+col"}, row * 256 + col, e.row * 256 + e.col);
    chk(cyc == e.due, "R5", {tag, " output cycle"}, cyc, e.due);
    chk(eof == e.eof, "R8", {tag, " eof"}, eof, e.eof);
  endtask

  always @(negedge clk) begin
    if (rst_n && p_ov) begin
      if (qp.size() == 0) chk(1'b0, "R5", "parallel unexpected out_valid", 1, 0);
      else compare("parallel", qp.pop_front(), p_om, int'(p_orow), int'(p_ocol), p_oe);
    end
    if (rst_n && s_ov) begin
      if (qs.size() == 0) chk(1'b0, "R5", "serial unexpected out_valid", 1, 0);
      else compare("serial", qs.pop_front(), s_om, int'(s_orow), int'(s_ocol), s_oe);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_models();
    m_lo = 2; m_hi = 1022; m_rows = 4; m_cols = 3;
    for (int k = 0; k < 2; k++) begin mrow[k] = 0; mcol[k] = 0; end
  endtask

  task automatic set_cfg(int lo, int hi, int rows, int cols);
    idle(4);
    cfg_lo = SUM_W'(lo); cfg_hi = SUM_W'(hi);
    cfg_rows = DIM_W'(rows); cfg_cols = DIM_W'(cols);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_lo = lo; m_hi = hi; m_rows = rows; m_cols = cols;
    for (int k = 0; k < 2; k++) begin mrow[k] = 0; mcol[k] = 0; end
  endtask

  task automatic send_par(int r, int g, int b);
    p_valid = 1'b1; p_sop = 1'($urandom_range(0, 1)); // R9: start flag must not matter
    p_r = CH_W'(r); p_g = CH_W'(g); p_b = CH_W'(b);
    push_exp(0, r, g, b);
    @(negedge clk);
    p_valid = 1'b0; p_sop = 1'b0;
  endtask

  task automatic ser_beat(int d, bit sop);
    s_valid = 1'b1; s_sop = sop; s_data = CH_W'(d);
    @(negedge clk);
    s_valid = 1'b0; s_sop = 1'b0;
  endtask

  task automatic ser_gap(int n);
    for (int i = 0; i < n; i++) begin
      s_data = CH_W'($urandom_range(0, 1023)); // R6: data with px_valid low is ignored
      s_sop  = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    s_sop = 1'b0;
  endtask

  task automatic send_ser(int r, int g, int b, int maxgap);
    ser_beat(r, 1'b1);
    ser_gap($urandom_range(0, maxgap));
    ser_beat(g, 1'b0);
    ser_gap($urandom_range(0, maxgap));
    s_valid = 1'b1; s_sop = 1'b0; s_data = CH_W'(b);
    push_exp(1, r, g, b);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic send_both(int r, int g, int b);
    send_par(r, g, b);
    send_ser(r, g, b, 0);
  endtask

  task automatic split_send(int t);
    int r, g, b;
    if (t < 0) t = 0;
    if (t > 3069) t = 3069;
    r = (t > 1023) ? 1023 : t;
    g = (t - r > 1023) ? 1023 : t - r;
    b = t - r - g;
    send_both(r, g, b);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    qp.delete(); qs.delete();
    idle(2);
    rst_n = 1'b1;
    reset_models();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog expired: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20111));
    reset_models();
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!p_ov && !s_ov, "R10", "out_valid after reset", int'(p_ov | s_ov), 0);

    // R3 default window edges and R1 extreme sums, default 4x3 frame
    split_send(1); split_send(2); split_send(1022); split_send(1023);
    split_send(0); split_send(3069);
    idle(5);

    // R2 single-value window, small frame
    set_cfg(100, 100, 2, 3);
    split_send(99); split_send(100); split_send(101);
    split_send(100); split_send(3069); split_send(100);
    idle(5);

    // R2 inverted window: every mask 0
    set_cfg(600, 599, 3, 2);
    split_send(599); split_send(600); split_send(0); split_send(3000);
    idle(5);

    // R7 serialized resync after partial pixels
    set_cfg(300, 900, 2, 2);
    ser_beat(700, 1'b1); ser_beat(700, 1'b0);
    send_ser(100, 200, 300, 1);
    ser_beat(5, 1'b1);
    send_ser(400, 300, 100, 0);
    ser_beat(9, 1'b0); ser_beat(9, 1'b0); ser_gap(2);
    send_ser(10, 10, 10, 2);
    idle(6);

    // R10 reset with pixels in flight, then default state again
    p_valid = 1'b1; p_r = 10'd1; p_g = 10'd1; p_b = 10'd0;
    s_valid = 1'b1; s_sop = 1'b0; s_data = 10'd0;
    @(negedge clk);
    p_valid = 1'b0; s_valid = 1'b0;
    do_reset();
    @(negedge clk);
    chk(!p_ov && !s_ov, "R10", "out_valid after in-flight reset", int'(p_ov | s_ov), 0);
    split_send(2); split_send(1);
    idle(5);

    // Random frames and windows, sums aimed at the window edges
    for (int it = 0; it < 40; it++) begin
      int lo, hi, rows, cols, npix;
      lo = $urandom_range(0, 1600);
      hi = ($urandom_range(0, 7) == 0 && lo > 0) ? lo - 1 : lo + $urandom_range(0, 1400);
      rows = $urandom_range(1, 5);
      cols = $urandom_range(1, 4);
      set_cfg(lo, hi, rows, cols);
      npix = rows * cols + $urandom_range(0, 6);
      for (int p = 0; p < npix; p++) begin
        int sel, r, g, b;
        sel = $urandom_range(0, 5);
        if (sel < 4) begin
          int t;
          t = (sel == 0) ? lo - 1 : (sel == 1) ? lo : (sel == 2) ? hi : hi + 1;
          if (t < 0) t = 0;
          if (t > 3069) t = 3069;
          r = (t > 1023) ? 1023 : t;
          g = (t - r > 1023) ? 1023 : t - r;
          b = t - r - g;
        end else begin
          r = $urandom_range(0, 1023); g = $urandom_range(0, 1023); b = $urandom_range(0, 1023);
        end
        send_par(r, g, b);
        if ($urandom_range(0, 2) == 0) begin
          p_r = CH_W'($urandom_range(0, 1023)); // R9: idle data ignored
          @(negedge clk);
        end
        send_ser(r, g, b, 2);
      end
    end

    idle(8);
    chk(qp.size() == 0, "R5", "parallel results missing", qp.size(), 0);
    chk(qs.size() == 0, "R5", "serial results missing", qs.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule